// File: doc/BRIEF.md
# Pulse Digitizer Control Sequencer

This block runs one pulse-height ADC channel behind a charge-sensitive detector chain. Two comparator outputs enter it asynchronously: a pulse-start indication and a peak indication. Both pass through two-flop synchronizers. The block powers up the ADC as soon as a pulse starts. When the peak shows, it strobes a conversion and then clocks in the 12-bit serial result, most significant bit first. After each real pulse it pulses the baseline-restore reset. If the peak never arrives within a programmable window, it gives up, puts the ADC back to sleep and raises a one-cycle timeout flag.

While the line is quiet, the sequencer can convert the channel with no pulse present. These samples are tagged as noise so that a downstream histogrammer can file them apart from real events. A noise conversion starts only after the pulse-start input has stayed low for a programmable interval. If a pulse begins while a noise conversion is still running, that conversion is dropped and the sequencer handles the real pulse.

Captured words leave on a valid/ready stream. The word, with its noise tag, is presented while `sample_valid` is high and stays unchanged until `sample_ready` is seen high at a clock edge. The sequencer starts no new work while a word waits. With `sample_ready` held high, `sample_valid` is high for exactly one clock.

Top module: `pds_sequencer`

## Requirements
- R1: During reset and immediately after it, `adc_wake`, `adc_convert`, `adc_read`, `blr_reset`, `timeout_flag` and `sample_valid` are all 0.
- R2: `adc_wake` goes high exactly 3 clock edges after a rising edge on `valid_async` that arrives while the sequencer is idle (two synchronizer flops plus one state update).
- R3: Once the ADC is awake, a rising edge on `peak_async` makes `adc_convert` go high 3 clock edges later, and it stays high for exactly 2 clocks.
- R4: Directly after the conversion strobe, `adc_read` is high for exactly 12 clocks. During those clocks `adc_sdata` is sampled once per clock, with the first sample being bit 11 (MSB first). `sample_data[11:0]` presents the assembled word.
- R5: `sample_valid` rises in the clock right after `adc_read` falls. `sample_valid`, `sample_data` and `sample_is_noise` hold steady until `sample_ready` is high at a clock edge. `sample_is_noise` is 0 for a pulse event and 1 for a noise sample.
- R6: If no peak arrives, `adc_wake` stays high for exactly `cfg_peak_timeout`+1 clocks and then falls. `timeout_flag` is high for the single clock in which `adc_wake` first reads low. No sample is produced.
- R7: After a pulse-event sample is accepted, `blr_reset` is high for exactly 4 clocks. After a noise sample it stays low.
- R8: With `noise_enable` high and `valid_async` low, a noise conversion begins (`adc_convert` rises) `cfg_quiet_len`+1 idle clocks after the sequencer returns to idle. With `noise_enable` low, no conversion happens without a pulse.
- R9: A rising `valid_async` during a noise conversion or readout discards that sample and keeps the ADC awake for the new pulse. The pulse then completes as an event tagged 0.
- R10: After a timeout, a `valid_async` that stays high does not wake the ADC again. A new low-to-high transition is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (nominally 10 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_async | input | 1 | Asynchronous pulse-start comparator |
| peak_async | input | 1 | Asynchronous peak-detect comparator |
| noise_enable | input | 1 | Allows untriggered noise conversions |
| cfg_quiet_len | input | 8 | Quiet idle clocks required before a noise conversion |
| cfg_peak_timeout | input | 8 | Peak wait window; wake lasts this value + 1 clocks |
| adc_sdata | input | 1 | Serial data from the ADC, MSB first |
| adc_wake | output | 1 | ADC power-up request |
| adc_convert | output | 1 | Conversion start strobe |
| adc_read | output | 1 | Serial readout enable, one bit per clock |
| blr_reset | output | 1 | Baseline-restore reset pulse |
| timeout_flag | output | 1 | One-clock flag when a peak wait expires |
| sample_data | output | 12 | Captured ADC word |
| sample_is_noise | output | 1 | 1 = noise sample, 0 = pulse event |
| sample_valid | output | 1 | Stream valid for the captured word |
| sample_ready | input | 1 | Stream ready from the consumer |

## Verification
A stuck or skipped state in the sequencer shows at the strobe pins within a few clocks. A missing or extra clock in the wake, conversion, readout or baseline-restore windows changes the pulse widths the bench counts edge by edge. A bad shift order or a lost bit appears in the first captured word, because the bench sweeps words such as all-ones, single-bit and alternating patterns. A quiet timer that is miscounted or not cleared shifts the start of the next noise conversion by at least one clock. A noise tag left over from an aborted conversion flips `sample_is_noise` on the very next event.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CONV,
    ST_READ,
    ST_DONE,
    ST_BLR
  } pds_state_t;
endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  // one independent two-stage chain per input bit
  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_in[g];
        stage2 <= stage1;
      end
    end
    assign sync_out[g] = stage2;
  end
endmodule

// File: rtl/pds_quiet_timer.sv
module pds_quiet_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt >= limit);

  // R8: the quiet count only grows while running
  assert_quiet_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pds_shift_capture.sv
module pds_shift_capture #(
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            sdata,
  output logic [BITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (shift_en) word <= {word[BITS-2:0], sdata};
  end
endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer #(
  parameter int ADC_BITS    = 12,
  parameter int CONV_CYCLES = 2,
  parameter int BLR_CYCLES  = 4,
  parameter int QUIET_W     = 8,
  parameter int TMO_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_async,
  input  logic                peak_async,
  input  logic                noise_enable,
  input  logic [QUIET_W-1:0]  cfg_quiet_len,
  input  logic [TMO_W-1:0]    cfg_peak_timeout,
  input  logic                adc_sdata,
  output logic                adc_wake,
  output logic                adc_convert,
  output logic                adc_read,
  output logic                blr_reset,
  output logic                timeout_flag,
  output logic [ADC_BITS-1:0] sample_data,
  output logic                sample_is_noise,
  output logic                sample_valid,
  input  logic                sample_ready
);
  import pds_pkg::*;

  localparam int PH_MAX = (ADC_BITS > CONV_CYCLES) ?
                          ((ADC_BITS > BLR_CYCLES) ? ADC_BITS : BLR_CYCLES) :
                          ((CONV_CYCLES > BLR_CYCLES) ? CONV_CYCLES : BLR_CYCLES);
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] CONV_LAST = PH_W'(CONV_CYCLES - 1);
  localparam logic [PH_W-1:0] READ_LAST = PH_W'(ADC_BITS - 1);
  localparam logic [PH_W-1:0] BLR_LAST  = PH_W'(BLR_CYCLES - 1);

  // synchronized comparators and their previous values
  logic [1:0] sync_v;
  logic       valid_s, peak_s, valid_prev, peak_prev;
  logic       valid_rise, peak_rise;

  pds_sync #(.WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({peak_async, valid_async}),
    .sync_out (sync_v)
  );
  assign valid_s = sync_v[0];
  assign peak_s  = sync_v[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_prev <= 1'b0;
      peak_prev  <= 1'b0;
    end else begin
      valid_prev <= valid_s;
      peak_prev  <= peak_s;
    end
  end
  assign valid_rise = valid_s && !valid_prev;
  assign peak_rise  = peak_s && !peak_prev;

  // sequencer state
  pds_state_t       state, state_n;
  logic [PH_W-1:0]  phase, phase_n;
  logic [TMO_W-1:0] tmo, tmo_n;
  logic             is_noise, noise_n, tflag_n;
  logic             quiet_done;

  pds_quiet_timer #(.CW(QUIET_W)) u_quiet (
    .clk   (clk),
    .rst_n (rst_n),
    .run   ((state == ST_IDLE) && !valid_s),
    .limit (cfg_quiet_len),
    .done  (quiet_done)
  );

  pds_shift_capture #(.BITS(ADC_BITS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (state == ST_READ),
    .sdata    (adc_sdata),
    .word     (sample_data)
  );

  always_comb begin
    state_n = state;
    phase_n = phase;
    tmo_n   = tmo;
    noise_n = is_noise;
    tflag_n = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (valid_rise) begin
          state_n = ST_ARMED;
          tmo_n   = '0;
          noise_n = 1'b0;
        end else if (noise_enable && quiet_done) begin
          state_n = ST_CONV;
          phase_n = '0;
          noise_n = 1'b1;
        end
      end
      ST_ARMED: begin
        if (peak_rise) begin
          state_n = ST_CONV;
          phase_n = '0;
        end else if (tmo == cfg_peak_timeout) begin
          state_n = ST_IDLE;
          tflag_n = 1'b1;
        end else begin
          tmo_n = tmo + 1'b1;
        end
      end
      ST_CONV, ST_READ: begin
        if (is_noise && valid_rise) begin
          state_n = ST_ARMED;
          tmo_n   = '0;
          noise_n = 1'b0;
        end else if (state == ST_CONV) begin
          if (phase == CONV_LAST) begin
            state_n = ST_READ;
            phase_n = '0;
          end else phase_n = phase + 1'b1;
        end else begin
          if (phase == READ_LAST) state_n = ST_DONE;
          else phase_n = phase + 1'b1;
        end
      end
      ST_DONE: begin
        if (sample_ready) begin
          state_n = is_noise ? ST_IDLE : ST_BLR;
          phase_n = '0;
        end
      end
      ST_BLR: begin
        if (phase == BLR_LAST) state_n = ST_IDLE;
        else phase_n = phase + 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      phase        <= '0;
      tmo          <= '0;
      is_noise     <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      state        <= state_n;
      phase        <= phase_n;
      tmo          <= tmo_n;
      is_noise     <= noise_n;
      timeout_flag <= tflag_n;
    end
  end

  assign adc_wake        = (state == ST_ARMED) || (state == ST_CONV) || (state == ST_READ);
  assign adc_convert     = (state == ST_CONV);
  assign adc_read        = (state == ST_READ);
  assign blr_reset       = (state == ST_BLR);
  assign sample_valid    = (state == ST_DONE);
  assign sample_is_noise = is_noise;

  // R2: an idle pulse start wakes the ADC at the next edge
  assert_wake_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_rise && state == ST_IDLE) |=> adc_wake);

  // R4: readout always follows a conversion strobe
  assert_read_after_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_read) |-> $past(adc_convert));

  // R4: strobes and stream valid never overlap
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adc_convert, adc_read, blr_reset, sample_valid}));

  // R5: a stalled word holds still
  assert_stall_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !sample_ready) |=>
      (sample_valid && $stable(sample_data) && $stable(sample_is_noise)));

  // R6: the timeout flag marks the end of a wake window
  assert_timeout_drops_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> (!adc_wake && $past(adc_wake)));

  // R7: baseline reset only after an accepted pulse event
  assert_blr_after_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blr_reset) |-> $past(sample_valid && sample_ready && !sample_is_noise));
endmodule

// File: tb/pds_sequencer_tb.sv
module pds_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_async = 1'b0;
  logic        peak_async = 1'b0;
  logic        noise_enable = 1'b0;
  logic [7:0]  cfg_quiet_len = 8'd4;
  logic [7:0]  cfg_peak_timeout = 8'd50;
  logic        adc_sdata = 1'b0;
  logic        adc_wake, adc_convert, adc_read, blr_reset, timeout_flag;
  logic [11:0] sample_data;
  logic        sample_is_noise, sample_valid;
  logic        sample_ready = 1'b1;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int sv_count = 0;
  int bit_idx = 0;
  logic [11:0] adc_word = 12'h123;

  always #4 clk = ~clk;

  pds_sequencer u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .valid_async      (valid_async),
    .peak_async       (peak_async),
    .noise_enable     (noise_enable),
    .cfg_quiet_len    (cfg_quiet_len),
    .cfg_peak_timeout (cfg_peak_timeout),
    .adc_sdata        (adc_sdata),
    .adc_wake         (adc_wake),
    .adc_convert      (adc_convert),
    .adc_read         (adc_read),
    .blr_reset        (blr_reset),
    .timeout_flag     (timeout_flag),
    .sample_data      (sample_data),
    .sample_is_noise  (sample_is_noise),
    .sample_valid     (sample_valid),
    .sample_ready     (sample_ready)
  );

  // serial ADC model: presents MSB first while read is enabled
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (sample_valid) sv_count <= sv_count + 1;
    if (adc_read) begin
      adc_sdata <= adc_word[11 - bit_idx];
      bit_idx   <= bit_idx + 1;
    end else begin
      bit_idx <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig(input int s);
    case (s)
      0: return adc_wake;
      1: return adc_convert;
      2: return adc_read;
      3: return blr_reset;
      default: return sample_valid;
    endcase
  endfunction

  // edges until a signal reads high at a falling edge
  task automatic edges_until(input int s, output int n);
    n = 0;
    while (!sig(s) && n < 2000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  // falling edges over which a signal stays high
  task automatic high_count(input int s, output int n);
    n = 0;
    while (sig(s) && n < 2000) begin
      n++; @(negedge clk);
    end
  endtask

  task automatic run_event(input logic [11:0] w, input int stall);
    int n;
    logic [11:0] held;
    adc_word = w;
    sample_ready = 1'b0;
    @(negedge clk);
    valid_async = 1'b1;
    edges_until(0, n);
    check(n == 3, "R2 wake latency", n, 3);
    repeat (2) @(negedge clk);
    peak_async = 1'b1;
    edges_until(1, n);
    check(n == 3, "R3 peak to convert", n, 3);
    high_count(1, n);
    check(n == 2, "R3 convert width", n, 2);
    high_count(2, n);
    check(n == 12, "R4 read width", n, 12);
    check(sample_valid == 1'b1, "R5 valid after read", sample_valid, 1);
    check(sample_data == w, "R4 captured word", sample_data, w);
    check(sample_is_noise == 1'b0, "R5 event tag", sample_is_noise, 0);
    held = sample_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(sample_valid && sample_data == held, "R5 stall hold", sample_data, held);
    end
    sample_ready = 1'b1;
    @(negedge clk);
    check(sample_valid == 1'b0, "R5 accepted", sample_valid, 0);
    high_count(3, n);
    check(n == 4, "R7 blr width", n, 4);
    valid_async = 1'b0;
    peak_async  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_timeout(input int t);
    int n;
    int sv0;
    int woke;
    cfg_peak_timeout = 8'(t);
    sv0 = sv_count;
    @(negedge clk);
    valid_async = 1'b1;
    edges_until(0, n);
    high_count(0, n);
    check(n == t + 1, "R6 wake window", n, t + 1);
    check(timeout_flag == 1'b1, "R6 flag high", timeout_flag, 1);
    @(negedge clk);
    check(timeout_flag == 1'b0, "R6 flag one clock", timeout_flag, 0);
    woke = 0;
    for (int i = 0; i < 20; i++) begin
      if (adc_wake) woke++;
      @(negedge clk);
    end
    check(woke == 0, "R10 held valid no rewake", woke, 0);
    check(sv_count == sv0, "R6 no sample", sv_count - sv0, 0);
    valid_async = 1'b0;
    repeat (4) @(negedge clk);
    cfg_peak_timeout = 8'd50;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int q;
    logic [11:0] w;
    logic [11:0] pat [6];
    pat = '{12'h000, 12'hFFF, 12'hA5A, 12'h001, 12'h800, 12'h7FE};

    // R1 reset state
    repeat (3) @(negedge clk);
    check({adc_wake, adc_convert, adc_read, blr_reset, timeout_flag, sample_valid} == 6'b0,
          "R1 in reset", {adc_wake, adc_convert, adc_read, blr_reset, timeout_flag, sample_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({adc_wake, adc_convert, adc_read, blr_reset, timeout_flag, sample_valid} == 6'b0,
          "R1 after reset", {adc_wake, adc_convert, adc_read, blr_reset, timeout_flag, sample_valid}, 0);

    // R2..R5, R7 event sweep
    for (int i = 0; i < 6; i++) run_event(pat[i], i);
    for (int k = 0; k < 12; k++) run_event(12'((k * 2531 + 17) & 12'hFFF), k % 3);

    // R6, R10 timeout sweep
    for (int t = 0; t < 6; t++) run_timeout(t);

    // R8 noise conversions
    sample_ready = 1'b1;
    adc_word = 12'h3C9;
    noise_enable = 1'b1;
    edges_until(4, n);
    check(sample_is_noise == 1'b1, "R8 first noise tag", sample_is_noise, 1);
    check(sample_data == 12'h3C9, "R4 noise word", sample_data, 12'h3C9);
    for (int j = 0; j < 6; j++) begin
      q = (j * j + j) % 13;
      w = 12'((j * 1433 + 291) & 12'hFFF);
      cfg_quiet_len = 8'(q);
      adc_word = w;
      edges_until(1, n);
      check(n == q + 2, "R8 quiet gap", n, q + 2);
      check(blr_reset == 1'b0, "R7 no blr after noise", blr_reset, 0);
      edges_until(4, n);
      check(sample_is_noise == 1'b1, "R5 noise tag", sample_is_noise, 1);
      check(sample_data == w, "R4 noise word", sample_data, w);
    end
    noise_enable = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (adc_convert) n++;
    end
    check(n == 0, "R8 disabled no noise", n, 0);

    // R9 noise conversion pre-empted by a pulse
    cfg_quiet_len = 8'd2;
    noise_enable = 1'b1;
    edges_until(1, n);
    valid_async = 1'b1;
    adc_word = 12'h5C3;
    begin
      int sv0;
      sv0 = sv_count;
      repeat (20) @(negedge clk);
      check(sv_count == sv0, "R9 noise discarded", sv_count - sv0, 0);
      check(adc_wake == 1'b1, "R9 wake kept", adc_wake, 1);
    end
    peak_async = 1'b1;
    edges_until(1, n);
    check(n == 3, "R9 convert after peak", n, 3);
    high_count(1, n);
    high_count(2, n);
    check(n == 12, "R9 read width", n, 12);
    check(sample_valid && sample_is_noise == 1'b0, "R9 event tag", sample_is_noise, 0);
    check(sample_data == 12'h5C3, "R9 event word", sample_data, 12'h5C3);
    noise_enable = 1'b0;
    @(negedge clk);
    high_count(3, n);
    check(n == 4, "R9 blr after event", n, 4);
    valid_async = 1'b0;
    peak_async = 1'b0;
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule